// File: doc/BRIEF.md
# Rotary-Stepped Square-Wave Clock Generator

This block turns a fixed reference clock into a square-wave system clock for a small 8-bit computer. The output rate is picked from a 1-2-5 ladder that spans six decades, from 1 Hz to 1 MHz with the default 16 MHz reference, and high and low phases are always the same length. A quadrature rotary knob walks up and down the ladder one rung per detent. The selected rung comes out as a binary index so that an outside display can show it.

Each knob input passes through two flip-flops. A seven-state decoder then follows the Gray sequence. The states are `ENC_REST` (both inputs low), `ENC_CW1`, `ENC_CW2` and `ENC_CW3` for a clockwise turn in progress, and `ENC_CCW1`, `ENC_CCW2` and `ENC_CCW3` for a counter-clockwise one.

The transitions are as follows:
- Clockwise, written {a,b}: `ENC_REST` -(10)-> `ENC_CW1` -(11)-> `ENC_CW2` -(01)-> `ENC_CW3` -(00)-> `ENC_REST`, and that last step emits an up step.
- Counter-clockwise: `ENC_REST` -(01)-> `ENC_CCW1` -(11)-> `ENC_CCW2` -(10)-> `ENC_CCW3` -(00)-> `ENC_REST`, and that last step emits a down step.
- Each in-progress state also steps back to the state before it when the inputs return to that state's code.
- Any other code leaves the state unchanged.

A saturating index register takes the up and down steps. A half-period counter toggles the output, and it only takes a new divide value at the rising edge of the output.

Top module: `clk_gen_top`

## Requirements
- R1: While `rst` is high, and on the cycles after it, `setting` is 0 and `clk_out` is low. After `rst` falls, the first rising edge of `clk_out` comes on the REF_HZ/(2*F_MIN_HZ)-th rising edge of `clk_ref`.
- R2: Index i selects the frequency F_MIN_HZ * m * 10^(i/3), where m is 1, 2 or 5 for i mod 3 equal to 0, 1 or 2. Each phase of `clk_out` then lasts REF_HZ/(2*frequency) reference cycles.
- R3: In every period of `clk_out`, the low phase is as long as the high phase that came just before it.
- R4: A complete clockwise detent raises `setting` by exactly one. On {enc_a,enc_b} this is the sequence 00, 10, 11, 01, 00.
- R5: A complete counter-clockwise detent lowers `setting` by exactly one. On {enc_a,enc_b} this is the sequence 00, 01, 11, 10, 00.
- R6: `setting` stays within 0 to 3*DECADES. A down detent at 0 and an up detent at the top leave it unchanged.
- R7: A partial turn that goes back to 00 by the way it came leaves `setting` unchanged.
- R8: `setting` changes on the fourth rising edge of `clk_ref` after the final 00 phase of a detent is applied.
- R9: A new setting first applies to the high phase that starts at the next rising edge of `clk_out`. Any phase already running, and the low phase that follows it, keep the old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock, REF_HZ |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Knob quadrature channel A, asynchronous |
| enc_b | input | 1 | Knob quadrature channel B, asynchronous |
| clk_out | output | 1 | Divided square-wave clock |
| setting | output | $clog2(3*DECADES+1) | Ladder index for the display |

## Verification
The index moves on the fourth reference edge after a detent's closing phase. The bench checks it one edge early, where it must still hold the old value, and then at that edge, where it must hold the new one. Output phase lengths are counted in reference cycles between level changes of `clk_out`, all sampled on the falling reference edge, so every count is exact. For the deferred-update check the bench turns the knob inside a high phase. It then expects that high phase and the following low phase at the old length, and only the next high phase at the new one. A scoreboard queue holds the expected index after every detent, and a monitor pops an entry at each change it sees.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

    typedef enum logic [2:0] {
        ENC_REST,
        ENC_CW1,
        ENC_CW2,
        ENC_CW3,
        ENC_CCW1,
        ENC_CCW2,
        ENC_CCW3
    } enc_state_e;

    // Cycles-per-half-period minus one for ladder rung idx (1-2-5 per decade).
    function automatic longint half_limit(input int idx, input longint ref_hz,
                                          input longint fmin_hz);
        longint f;
        f = fmin_hz;
        for (int d = 0; d < idx / 3; d++) f = f * 10;
        case (idx % 3)
            1:       f = f * 2;
            2:       f = f * 5;
            default: f = f * 1;
        endcase
        return ref_hz / (2 * f) - 1;
    endfunction

endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            q_o    <= '0;
        end else begin
            meta_q <= d_i;
            q_o    <= meta_q;
        end
    end
endmodule

// File: rtl/qdec_fsm.sv
module qdec_fsm
    import clkgen_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] ab_i,
    output logic       up_o,
    output logic       dn_o
);
    enc_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENC_REST: begin
                if (ab_i == 2'b10)      state_d = ENC_CW1;
                else if (ab_i == 2'b01) state_d = ENC_CCW1;
            end
            ENC_CW1: begin
                if (ab_i == 2'b11)      state_d = ENC_CW2;
                else if (ab_i == 2'b00) state_d = ENC_REST;
            end
            ENC_CW2: begin
                if (ab_i == 2'b01)      state_d = ENC_CW3;
                else if (ab_i == 2'b10) state_d = ENC_CW1;
            end
            ENC_CW3: begin
                if (ab_i == 2'b00)      state_d = ENC_REST;
                else if (ab_i == 2'b11) state_d = ENC_CW2;
            end
            ENC_CCW1: begin
                if (ab_i == 2'b11)      state_d = ENC_CCW2;
                else if (ab_i == 2'b00) state_d = ENC_REST;
            end
            ENC_CCW2: begin
                if (ab_i == 2'b10)      state_d = ENC_CCW3;
                else if (ab_i == 2'b01) state_d = ENC_CCW1;
            end
            ENC_CCW3: begin
                if (ab_i == 2'b00)      state_d = ENC_REST;
                else if (ab_i == 2'b11) state_d = ENC_CCW2;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ENC_REST;
        else     state_q <= state_d;
    end

    // Registered step outputs: one pulse per completed detent
    always_ff @(posedge clk) begin
        if (rst) begin
            up_o <= 1'b0;
            dn_o <= 1'b0;
        end else begin
            up_o <= (state_q == ENC_CW3)  && (ab_i == 2'b00);
            dn_o <= (state_q == ENC_CCW3) && (ab_i == 2'b00);
        end
    end
endmodule

// File: rtl/rate_sel.sv
module rate_sel #(
    parameter int NSET  = 19,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             up_i,
    input  logic             dn_i,
    output logic [IDX_W-1:0] idx_o
);
    localparam logic [IDX_W-1:0] TOP = IDX_W'(NSET - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_o <= '0;
        end else if (up_i && idx_o != TOP) begin
            idx_o <= idx_o + IDX_W'(1);
        end else if (dn_i && idx_o != '0) begin
            idx_o <= idx_o - IDX_W'(1);
        end
    end
endmodule

// File: rtl/half_div.sv
module half_div #(
    parameter int                 CNT_W   = 23,
    parameter logic [CNT_W-1:0]   RST_LIM = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] lim_i,
    output logic             clk_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            lim_q <= RST_LIM;
            clk_o <= 1'b0;
        end else if (cnt_q == lim_q) begin
            cnt_q <= '0;
            clk_o <= ~clk_o;
            // new divide value only at the start of a high phase
            if (!clk_o) lim_q <= lim_i;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/clk_gen_top.sv
module clk_gen_top #(
    parameter int unsigned REF_HZ   = 16_000_000,
    parameter int unsigned F_MIN_HZ = 1,
    parameter int unsigned DECADES  = 6,
    localparam int NSET  = 3 * DECADES + 1,
    localparam int IDX_W = $clog2(NSET)
) (
    input  logic             clk_ref,
    input  logic             rst,
    input  logic             enc_a,
    input  logic             enc_b,
    output logic             clk_out,
    output logic [IDX_W-1:0] setting
);
    localparam longint MAX_HALF = longint'(REF_HZ) / (2 * longint'(F_MIN_HZ));
    localparam int     CNT_W    = $clog2(MAX_HALF);
    localparam int     TAB_N    = 2 ** IDX_W;
    localparam logic [CNT_W-1:0] RST_LIM =
        CNT_W'(clkgen_pkg::half_limit(0, longint'(REF_HZ), longint'(F_MIN_HZ)));

    logic [1:0]       ab_s;
    logic             step_up, step_dn;
    logic [CNT_W-1:0] lim_tab [TAB_N];

    for (genvar g = 0; g < TAB_N; g++) begin : g_tab
        localparam int SEL = (g < NSET) ? g : NSET - 1;
        assign lim_tab[g] =
            CNT_W'(clkgen_pkg::half_limit(SEL, longint'(REF_HZ), longint'(F_MIN_HZ)));
    end

    qdec_sync #(.W(2)) u_sync (
        .clk (clk_ref),
        .rst (rst),
        .d_i ({enc_a, enc_b}),
        .q_o (ab_s)
    );

    qdec_fsm u_fsm (
        .clk  (clk_ref),
        .rst  (rst),
        .ab_i (ab_s),
        .up_o (step_up),
        .dn_o (step_dn)
    );

    rate_sel #(.NSET(NSET), .IDX_W(IDX_W)) u_sel (
        .clk   (clk_ref),
        .rst   (rst),
        .up_i  (step_up),
        .dn_i  (step_dn),
        .idx_o (setting)
    );

    half_div #(.CNT_W(CNT_W), .RST_LIM(RST_LIM)) u_div (
        .clk   (clk_ref),
        .rst   (rst),
        .lim_i (lim_tab[setting]),
        .clk_o (clk_out)
    );
endmodule

// File: rtl/clk_gen_chk.sv
module clk_gen_chk #(
    parameter int NSET  = 19,
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             clk_out,
    input logic [IDX_W-1:0] setting
);
    logic        co_q;
    logic        hi_seen;
    logic [31:0] run;
    logic [31:0] hi_len;

    // Phase-length bookkeeping seen only from the output pin
    always_ff @(posedge clk) begin
        if (rst) begin
            co_q    <= 1'b0;
            hi_seen <= 1'b0;
            run     <= '0;
            hi_len  <= '0;
        end else begin
            co_q <= clk_out;
            if (clk_out != co_q) begin
                run <= 32'd1;
                if (!clk_out) begin
                    hi_len  <= run;
                    hi_seen <= 1'b1;
                end
            end else begin
                run <= run + 32'd1;
            end
        end
    end

    // R1: reset drives outputs to their idle values
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (clk_out == 1'b0 && setting == '0));

    // R3: low phase matches the high phase just before it
    p_equal_phases_r3: assert property (@(posedge clk) disable iff (rst)
        (hi_seen && clk_out && !co_q) |-> (run == hi_len));

    // R4, R5: index moves by at most one rung per cycle
    p_single_step_r4: assert property (@(posedge clk) disable iff (rst)
        (setting != $past(setting)) |->
        (setting == $past(setting) + IDX_W'(1) || setting == $past(setting) - IDX_W'(1)));

    // R6: index never leaves the ladder
    p_in_range_r6: assert property (@(posedge clk) disable iff (rst)
        setting <= IDX_W'(NSET - 1));
endmodule

bind clk_gen_top clk_gen_chk #(.NSET(NSET), .IDX_W(IDX_W)) u_chk (
    .clk     (clk_ref),
    .rst     (rst),
    .clk_out (clk_out),
    .setting (setting)
);

// File: tb/clk_gen_top_test.sv
module clk_gen_top_test;
    localparam int REF  = 16_000_000;
    localparam int FMIN = 1000;
    localparam int DEC  = 3;
    localparam int NS   = 3 * DEC + 1;
    localparam int IW   = $clog2(NS);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ea  = 1'b0;
    logic          eb  = 1'b0;
    logic          clk_out;
    logic [IW-1:0] setting;

    int n_chk = 0;
    int n_bad = 0;
    int model = 0;
    int exp_q[$];
    int popped;
    logic [IW-1:0] seen;
    bit mon_en = 1'b0;

    always #5 clk = ~clk;

    clk_gen_top #(.REF_HZ(REF), .F_MIN_HZ(FMIN), .DECADES(DEC)) uut (
        .clk_ref (clk_ref_w),
        .rst     (rst),
        .enc_a   (ea),
        .enc_b   (eb),
        .clk_out (clk_out),
        .setting (setting)
    );
    wire clk_ref_w = clk;

    function automatic int exp_half(input int idx);
        int f = FMIN;
        for (int d = 0; d < idx / 3; d++) f = f * 10;
        if (idx % 3 == 1) f = f * 2;
        if (idx % 3 == 2) f = f * 5;
        return REF / (2 * f);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Scoreboard monitor: every index change must match the next queued item
    always @(negedge clk) begin
        if (mon_en && setting != seen) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4/R5 unexpected index change", int'(setting), int'(seen));
            end else begin
                popped = exp_q.pop_front();
                check(int'(setting) == popped, "R4/R5 scoreboard index", int'(setting), popped);
            end
            seen = setting;
        end
    end

    task automatic phase(input logic [1:0] ab);
        @(negedge clk);
        {ea, eb} = ab;
        repeat (5) @(negedge clk);
    endtask

    // Driver: full detent, expected index pushed before the closing phase
    task automatic turn(input bit cw);
        int nxt;
        if (cw) begin
            phase(2'b10); phase(2'b11); phase(2'b01);
            nxt = (model < NS - 1) ? model + 1 : model;
        end else begin
            phase(2'b01); phase(2'b11); phase(2'b10);
            nxt = (model > 0) ? model - 1 : model;
        end
        if (nxt != model) exp_q.push_back(nxt);
        model = nxt;
        phase(2'b00);
    endtask

    // Wait until clk_out is seen at lvl; n = falling ref edges waited
    task automatic next_edge(input logic lvl, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (clk_out != lvl);
    endtask

    task automatic measure(input int idx);
        int d, h, l;
        next_edge(1'b0, d);
        next_edge(1'b1, d);
        next_edge(1'b0, h);
        next_edge(1'b1, l);
        check(h == exp_half(idx), "R2 high phase length", h, exp_half(idx));
        check(l == h, "R3 low equals high", l, h);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200_000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired (R1..all) actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        int n, a, b, c;
        repeat (4) @(negedge clk);
        check(setting == '0, "R1 reset setting", int'(setting), 0);
        check(clk_out == 1'b0, "R1 reset clk_out", int'(clk_out), 0);
        rst  = 1'b0;
        seen = setting;
        mon_en = 1'b1;
        next_edge(1'b1, n);
        check(n == exp_half(0), "R1 first rising edge", n, exp_half(0));

        // R6: down at bottom rung
        turn(1'b0);
        repeat (4) @(negedge clk);
        check(setting == '0, "R6 saturate low", int'(setting), 0);

        // R8: exact update latency
        phase(2'b10); phase(2'b11); phase(2'b01);
        exp_q.push_back(1);
        model = 1;
        @(negedge clk);
        {ea, eb} = 2'b00;
        repeat (3) @(negedge clk);
        check(setting == IW'(0), "R8 still old after 3 edges", int'(setting), 0);
        @(negedge clk);
        check(setting == IW'(1), "R8 new on 4th edge", int'(setting), 1);
        repeat (4) @(negedge clk);

        // R4: climb to top
        for (int i = 0; i < NS - 2; i++) turn(1'b1);
        repeat (4) @(negedge clk);
        check(int'(setting) == NS - 1, "R4 reached top rung", int'(setting), NS - 1);
        turn(1'b1);
        repeat (4) @(negedge clk);
        check(int'(setting) == NS - 1, "R6 saturate high", int'(setting), NS - 1);
        measure(NS - 1);

        // R5: step down
        turn(1'b0);
        repeat (4) @(negedge clk);
        check(int'(setting) == NS - 2, "R5 one step down", int'(setting), NS - 2);
        measure(NS - 2);
        turn(1'b0);
        turn(1'b0);
        measure(NS - 4);

        // R7: partial turns reversed
        phase(2'b10); phase(2'b11); phase(2'b10); phase(2'b00);
        phase(2'b01); phase(2'b00);
        repeat (4) @(negedge clk);
        check(int'(setting) == NS - 4, "R7 partial turn no change", int'(setting), NS - 4);

        turn(1'b0); turn(1'b0); turn(1'b0);
        measure(3);

        // R9: change inside a high phase (measure ended just after a rising edge)
        turn(1'b0);
        next_edge(1'b0, a);
        next_edge(1'b1, b);
        next_edge(1'b0, c);
        a = a + 0;
        check(a + 31 >= exp_half(3) && a <= exp_half(3), "R9 current high kept", a, exp_half(3));
        check(b == exp_half(3), "R9 following low kept old", b, exp_half(3));
        check(c == exp_half(2), "R9 next high uses new", c, exp_half(2));
        next_edge(1'b1, n);
        check(n == exp_half(2), "R3 low after change", n, exp_half(2));

        check(exp_q.size() == 0, "R4/R5 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end
endmodule